// File: doc/BRIEF.md
# Read Output Latency Pipeline

This block forms the read return path of a single-data-rate synchronous DRAM. The memory core hands it one read beat per clock, and the block holds each beat back by the programmed column latency of 1, 2 or 3 clocks. It then presents the beat on a 16-bit output with one output-enable per byte lane. A low output-enable stands in for a high-impedance data pin. The core ends a burst simply by ceasing to issue beats. A precharge or burst-stop is signalled with a cut strobe: it discards the beat offered on that same edge and lets the beats already in flight drain.

Each byte lane has its own mask input, and that mask acts on two paths. On reads it blanks the lane two clocks after it is sampled, whatever the column latency. On writes it removes the lane's byte enable in the same cycle. A low clock enable freezes every stage. A latency reprogramming request waits until no beat is in flight, so a beat never changes its delay while it is in transit.

Top module: `sdr_read_pipe`

## Requirements
- R1: After reset (asynchronous, active low) both output-enables and all data bits are 0 and the column latency is 2; a reset mid-run empties the pipeline at once.
- R2: Latency code 3'b001 selects 1 clock, 3'b010 selects 2 and 3'b011 selects 3. A beat accepted at edge t is shown on the outputs from edge t+CL-1, so the host captures it at edge t+CL.
- R3: A load whose code is any other value (000, 1xx) is ignored and the latency stays unchanged.
- R4: A loaded latency is applied at the first clock-enabled edge at which no beat is in flight and no beat is accepted. Beats already in flight keep the latency they entered with.
- R5: Beats accepted on consecutive edges leave on consecutive cycles with no gap.
- R6: When the cut strobe is high at edge s, the beat offered at s is dropped. Exactly CL-1 earlier beats are still shown, after edges s to s+CL-2: 2 at CL 3, 1 at CL 2, none at CL 1.
- R7: After the last beat of a burst, both output-enables return to 0 and the data returns to 0.
- R8: A read mask bit sampled high at edge e disables its lane (enable 0, data 0) in the output state after edge e+1, which is the beat the host captures at edge e+2. This holds for every latency.
- R9: Mask bit 0 controls data bits 7:0 and enable bit 0; mask bit 1 controls data bits 15:8 and enable bit 1. Each acts without regard to the other.
- R10: The write byte enable of lane l equals clock enable AND write valid AND NOT mask l, in the same cycle, with no register.
- R11: While clock enable is low, no beat, cut, mask or latency load is taken, and every stage and output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low freezes all stages |
| lat_load | input | 1 | Request to reprogram the column latency |
| lat_code | input | 3 | Latency code (001, 010, 011 legal) |
| rd_beat_vld | input | 1 | Core offers a read beat this edge |
| rd_beat_data | input | 16 | Read beat data from the core |
| rd_cut | input | 1 | Precharge or burst stop: drop this edge's beat |
| dqm | input | 2 | Per-lane mask, bit 0 = low byte |
| wr_vld | input | 1 | Write data present this cycle |
| wr_be | output | 2 | Per-lane write byte enable, zero latency |
| dq_oe | output | 2 | Per-lane output enable (0 = high impedance) |
| dq_out | output | 16 | Read data, zero in disabled lanes |

## Verification
The bench builds the block with its defaults: 16 data bits in two byte lanes and a read-mask latency of 2. With these values the lane split, the two-clock mask delay and the same-cycle write mask are each seen in isolation. Each of the three legal latencies is measured from the ports. Truncation is driven at latencies 1, 2 and 3, so the drain counts of 0, 1 and 2 beats are all observed. A latency load is issued while a beat is in flight, which shows that the change is deferred until the pipeline is empty.

// File: rtl/sdr_rdpipe_pkg.sv
`timescale 1ns/1ps
package sdr_rdpipe_pkg;
    localparam int MODE_W  = 3;
    localparam int MAX_LAT = 3;
    localparam int LAT_W   = $clog2(MAX_LAT + 1);

    typedef logic [LAT_W-1:0] lat_t;

    localparam lat_t RESET_LAT = LAT_W'(2);

    typedef struct packed {
        lat_t cur;
        logic pend;
        lat_t nxt;
    } lat_state_t;

    // Map a mode-field code to a latency; zero marks a reserved code.
    function automatic lat_t decode_lat(input logic [MODE_W-1:0] code);
        case (code)
            3'b001:  return LAT_W'(1);
            3'b010:  return LAT_W'(2);
            3'b011:  return LAT_W'(3);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/sdr_rdpipe_lat.sv
`timescale 1ns/1ps
module sdr_rdpipe_lat
    import sdr_rdpipe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              load,
    input  logic [MODE_W-1:0] code,
    input  logic              busy,
    input  logic              accept,
    output lat_t              lat
);
    lat_state_t st_d, st_q;
    lat_t       dec;

    always_comb begin
        st_d = st_q;
        dec  = decode_lat(code);
        if (cke) begin
            // pending value lands only on an empty pipe with nothing entering
            if (st_q.pend && !busy && !accept) begin
                st_d.cur  = st_q.nxt;
                st_d.pend = 1'b0;
            end
            if (load && dec != '0) begin
                st_d.pend = 1'b1;
                st_d.nxt  = dec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cur: RESET_LAT, pend: 1'b0, nxt: RESET_LAT};
        else        st_q <= st_d;
    end

    assign lat = st_q.cur;
endmodule

// File: rtl/sdr_rdpipe_beats.sv
`timescale 1ns/1ps
module sdr_rdpipe_beats
    import sdr_rdpipe_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = MAX_LAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  lat_t              lat,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data,
    output logic              busy
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } beat_t;

    beat_t [DEPTH-1:0] stg_d, stg_q;
    logic  [DEPTH-1:0] vld_vec;

    always_comb begin
        stg_d = stg_q;
        if (cke) begin
            for (int i = 0; i < DEPTH - 1; i++) stg_d[i] = stg_q[i+1];
            stg_d[DEPTH-1] = '0;
            // a new beat enters at the slot that is CL stages from the output
            if (in_vld) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (int'(lat) == i + 1) stg_d[i] = '{vld: 1'b1, data: in_data};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
        assign vld_vec[g] = stg_q[g].vld;
    end

    assign busy     = |vld_vec;
    assign out_vld  = stg_q[0].vld;
    assign out_data = stg_q[0].data;
endmodule

// File: rtl/sdr_rdpipe_mask.sv
`timescale 1ns/1ps
module sdr_rdpipe_mask #(
    parameter int LANES = 2,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic [LANES-1:0] mask_in,
    output logic [LANES-1:0] mask_out
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DEPTH-1:0] sh_d, sh_q;

        if (DEPTH == 1) begin : g_one
            always_comb sh_d = cke ? mask_in[l] : sh_q;
        end else begin : g_many
            always_comb sh_d = cke ? {sh_q[DEPTH-2:0], mask_in[l]} : sh_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign mask_out[l] = sh_q[DEPTH-1];
    end
endmodule

// File: rtl/sdr_rdpipe_wmask.sv
`timescale 1ns/1ps
module sdr_rdpipe_wmask #(
    parameter int LANES = 2
) (
    input  logic             cke,
    input  logic             wr_vld,
    input  logic [LANES-1:0] dqm,
    output logic [LANES-1:0] be
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign be[l] = cke & wr_vld & ~dqm[l];
    end
endmodule

// File: rtl/sdr_read_pipe.sv
`timescale 1ns/1ps
module sdr_read_pipe
    import sdr_rdpipe_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int LANES    = 2,
    parameter int MASK_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              lat_load,
    input  logic [MODE_W-1:0] lat_code,
    input  logic              rd_beat_vld,
    input  logic [DATA_W-1:0] rd_beat_data,
    input  logic              rd_cut,
    input  logic [LANES-1:0]  dqm,
    input  logic              wr_vld,
    output logic [LANES-1:0]  wr_be,
    output logic [LANES-1:0]  dq_oe,
    output logic [DATA_W-1:0] dq_out
);
    localparam int LANE_W = DATA_W / LANES;

    lat_t              lat_cur;
    logic              pipe_busy;
    logic              beat_in;
    logic              beat_accept;
    logic              head_vld;
    logic [DATA_W-1:0] head_data;
    logic [LANES-1:0]  lane_mask;

    assign beat_in     = rd_beat_vld & ~rd_cut;
    assign beat_accept = cke & beat_in;

    sdr_rdpipe_lat u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .cke    (cke),
        .load   (lat_load),
        .code   (lat_code),
        .busy   (pipe_busy),
        .accept (beat_accept),
        .lat    (lat_cur)
    );

    sdr_rdpipe_beats #(.DATA_W(DATA_W), .DEPTH(MAX_LAT)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke      (cke),
        .lat      (lat_cur),
        .in_vld   (beat_in),
        .in_data  (rd_beat_data),
        .out_vld  (head_vld),
        .out_data (head_data),
        .busy     (pipe_busy)
    );

    sdr_rdpipe_mask #(.LANES(LANES), .DEPTH(MASK_LAT)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke      (cke),
        .mask_in  (dqm),
        .mask_out (lane_mask)
    );

    sdr_rdpipe_wmask #(.LANES(LANES)) u_wmask (
        .cke    (cke),
        .wr_vld (wr_vld),
        .dqm    (dqm),
        .be     (wr_be)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane_out
        assign dq_oe[l] = head_vld & ~lane_mask[l];
        assign dq_out[l*LANE_W +: LANE_W] = dq_oe[l] ? head_data[l*LANE_W +: LANE_W]
                                                     : '0;
    end
endmodule

// File: rtl/sdr_rdpipe_chk.sv
`timescale 1ns/1ps
module sdr_rdpipe_chk
    import sdr_rdpipe_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              rd_cut,
    input logic [LANES-1:0]  dqm,
    input logic [LANES-1:0]  wr_be,
    input logic [LANES-1:0]  dq_oe,
    input logic [DATA_W-1:0] dq_out,
    input lat_t              lat_cur,
    input logic              pipe_busy
);
    localparam int LANE_W = DATA_W / LANES;

    assert_lat_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lat_cur != '0);

    assert_lat_frozen_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_busy |=> $stable(lat_cur));

    assert_cut_cl1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && rd_cut && lat_cur == LAT_W'(1)) |=> (dq_oe == '0));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_busy |-> (dq_oe == '0));

    assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(dq_oe) && $stable(dq_out)));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assert_rd_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cke && dqm[l]) ##1 cke |=> !dq_oe[l]);

        assert_lane_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !dq_oe[l] |-> (dq_out[l*LANE_W +: LANE_W] == '0));

        assert_wr_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
            dqm[l] |-> !wr_be[l]);
    end
endmodule

bind sdr_read_pipe sdr_rdpipe_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .rd_cut    (rd_cut),
    .dqm       (dqm),
    .wr_be     (wr_be),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out),
    .lat_cur   (lat_cur),
    .pipe_busy (pipe_busy)
);

// File: tb/sdr_read_pipe_test.sv
`timescale 1ns/1ps
module sdr_read_pipe_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b0;
    logic        lat_load = 1'b0;
    logic [2:0]  lat_code = 3'b000;
    logic        rd_beat_vld = 1'b0;
    logic [15:0] rd_beat_data = '0;
    logic        rd_cut = 1'b0;
    logic [1:0]  dqm = 2'b00;
    logic        wr_vld = 1'b0;
    logic [1:0]  wr_be;
    logic [1:0]  dq_oe;
    logic [15:0] dq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_read_pipe uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .lat_load(lat_load), .lat_code(lat_code),
        .rd_beat_vld(rd_beat_vld), .rd_beat_data(rd_beat_data), .rd_cut(rd_cut),
        .dqm(dqm), .wr_vld(wr_vld), .wr_be(wr_be), .dq_oe(dq_oe), .dq_out(dq_out)
    );

    typedef struct packed {
        logic        c;
        logic        rv;
        logic [15:0] d;
        logic        ct;
        logic [1:0]  m;
        logic        wv;
        logic [1:0]  e_oe;
        logic [15:0] e_out;
        logic [1:0]  e_be;
    } vec_t;

    // Runs at latency 2; expected state is the one seen just after each edge.
    localparam vec_t VECS [14] = '{
        '{1'b1, 1'b1, 16'hA001, 1'b0, 2'b00, 1'b1, 2'b00, 16'h0000, 2'b11},
        '{1'b1, 1'b1, 16'hA002, 1'b0, 2'b01, 1'b1, 2'b11, 16'hA001, 2'b10},
        '{1'b1, 1'b1, 16'hA003, 1'b0, 2'b00, 1'b0, 2'b10, 16'hA000, 2'b00},
        '{1'b1, 1'b0, 16'h0000, 1'b0, 2'b00, 1'b0, 2'b11, 16'hA003, 2'b00},
        '{1'b1, 1'b0, 16'h0000, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0000, 2'b00},
        '{1'b1, 1'b1, 16'hB001, 1'b0, 2'b10, 1'b1, 2'b00, 16'h0000, 2'b01},
        '{1'b1, 1'b1, 16'hB002, 1'b0, 2'b00, 1'b0, 2'b01, 16'h0001, 2'b00},
        '{1'b0, 1'b1, 16'hFFFF, 1'b0, 2'b11, 1'b1, 2'b01, 16'h0001, 2'b00},
        '{1'b1, 1'b0, 16'h0000, 1'b1, 2'b00, 1'b0, 2'b11, 16'hB002, 2'b00},
        '{1'b1, 1'b0, 16'h0000, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0000, 2'b00},
        '{1'b1, 1'b1, 16'hC001, 1'b0, 2'b00, 1'b1, 2'b00, 16'h0000, 2'b11},
        '{1'b1, 1'b1, 16'hC002, 1'b0, 2'b00, 1'b0, 2'b11, 16'hC001, 2'b00},
        '{1'b1, 1'b1, 16'hC003, 1'b1, 2'b00, 1'b0, 2'b11, 16'hC002, 2'b00},
        '{1'b1, 1'b0, 16'h0000, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0000, 2'b00}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic rv, input logic [15:0] d,
                        input logic ct, input logic [1:0] m, input logic wv,
                        input logic ld, input logic [2:0] code);
        @(negedge clk);
        cke = c; rd_beat_vld = rv; rd_beat_data = d; rd_cut = ct;
        dqm = m; wr_vld = wv; lat_load = ld; lat_code = code;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(1'b1, 1'b0, 16'h0, 1'b0, 2'b00, 1'b0, 1'b0, 3'b000);
    endtask

    task automatic beat(input logic [15:0] d, input logic ct);
        step(1'b1, 1'b1, d, ct, 2'b00, 1'b0, 1'b0, 3'b000);
    endtask

    task automatic set_lat(input logic [2:0] code);
        step(1'b1, 1'b0, 16'h0, 1'b0, 2'b00, 1'b0, 1'b1, code);
        idle();
    endtask

    // Clocks from beat entry to the first state showing it (1 means same edge).
    task automatic measure(output int lat);
        lat = 0;
        beat(16'h5A5A, 1'b0);
        for (int n = 1; n <= 5; n++) begin
            if (lat == 0 && dq_oe == 2'b11 && dq_out == 16'h5A5A) lat = n;
            idle();
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int lat;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "oe in reset", 32'(dq_oe), 32'h0);
        chk("R1", "data in reset", 32'(dq_out), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "oe after reset", 32'(dq_oe), 32'h0);
        chk("R10", "be idle", 32'(wr_be), 32'h0);
        measure(lat);
        chk("R1", "reset latency", 32'(lat), 32'd2);

        // table walk: R2 R5 R7 R8 R9 R10 R11 R6 at latency 2
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            cke = VECS[i].c; rd_beat_vld = VECS[i].rv; rd_beat_data = VECS[i].d;
            rd_cut = VECS[i].ct; dqm = VECS[i].m; wr_vld = VECS[i].wv;
            lat_load = 1'b0;
            #1;
            chk("R10", $sformatf("vec %0d write enable", i), 32'(wr_be), 32'(VECS[i].e_be));
            @(posedge clk);
            #1;
            chk("R2 R5 R6 R8", $sformatf("vec %0d oe", i), 32'(dq_oe), 32'(VECS[i].e_oe));
            chk("R7 R9 R11", $sformatf("vec %0d data", i), 32'(dq_out), 32'(VECS[i].e_out));
        end
        idle(); idle();

        // R3: reserved codes leave latency alone
        set_lat(3'b100); measure(lat);
        chk("R3", "code 100", 32'(lat), 32'd2);
        set_lat(3'b000); measure(lat);
        chk("R3", "code 000", 32'(lat), 32'd2);
        set_lat(3'b111); measure(lat);
        chk("R3", "code 111", 32'(lat), 32'd2);

        // R2: each legal latency
        set_lat(3'b001); measure(lat);
        chk("R2", "latency 1", 32'(lat), 32'd1);
        set_lat(3'b011); measure(lat);
        chk("R2", "latency 3", 32'(lat), 32'd3);

        // R6 at latency 3: two beats drain after the cut
        beat(16'hE001, 1'b0);
        beat(16'hE002, 1'b0);
        beat(16'hE003, 1'b0);
        chk("R2", "cl3 first beat", 32'(dq_out), 32'hE001);
        beat(16'hE004, 1'b1);
        chk("R6", "cl3 drain 1", 32'(dq_out), 32'hE002);
        idle();
        chk("R6", "cl3 drain 2", 32'(dq_out), 32'hE003);
        idle();
        chk("R6", "cl3 cut beat dropped", 32'(dq_oe), 32'h0);
        idle();

        set_lat(3'b010); measure(lat);
        chk("R2", "latency 2 again", 32'(lat), 32'd2);

        // R6 at latency 1: nothing drains
        set_lat(3'b001);
        beat(16'hF001, 1'b0);
        chk("R2", "cl1 beat", 32'(dq_out), 32'hF001);
        beat(16'hF002, 1'b1);
        chk("R6", "cl1 no drain", 32'(dq_oe), 32'h0);
        idle();

        // R8 at latency 1: mask delay does not follow CL
        step(1'b1, 1'b1, 16'h1111, 1'b0, 2'b11, 1'b0, 1'b0, 3'b000);
        chk("R8", "mask not yet", 32'(dq_oe), 32'h3);
        step(1'b1, 1'b1, 16'h2222, 1'b0, 2'b00, 1'b0, 1'b0, 3'b000);
        chk("R8", "mask blanks oe", 32'(dq_oe), 32'h0);
        chk("R8", "mask blanks data", 32'(dq_out), 32'h0);
        idle(); idle();

        // R4: load during flight is deferred
        set_lat(3'b011);
        step(1'b1, 1'b1, 16'h7001, 1'b0, 2'b00, 1'b0, 1'b1, 3'b001);
        chk("R4", "beat keeps old latency t", 32'(dq_oe), 32'h0);
        idle();
        chk("R4", "beat keeps old latency t+1", 32'(dq_oe), 32'h0);
        idle();
        chk("R4", "beat at old latency", 32'(dq_out), 32'h7001);
        idle(); idle();
        measure(lat);
        chk("R4", "new latency after drain", 32'(lat), 32'd1);

        // R1: reset mid-run
        set_lat(3'b011);
        beat(16'h9001, 1'b0);
        beat(16'h9002, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        rd_beat_vld = 1'b0;
        #1;
        chk("R1", "reset empties oe", 32'(dq_oe), 32'h0);
        @(posedge clk); #1;
        chk("R1", "reset holds empty", 32'(dq_oe), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        measure(lat);
        chk("R1", "latency back to 2", 32'(lat), 32'd2);

        finish_run();
    end
endmodule